// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches a byte-wide receive stream coming out of an Ethernet MAC and decides, once per frame, where that frame should go. A frame can go to the UDP transport path or to the internal responder path, which answers address-resolution requests and echo requests. Otherwise the frame is discarded. The filter does not store the header. Instead, each header field is compared with its expected value as the byte arrives, and a bank of per-field match flags carries the result to the end of the frame. The filter neither buffers payload nor builds replies.

The block is controlled at run time by these inputs:
- the station's MAC address, IPv4 address and UDP port;
- two enable sources;
- a flag that restricts the block to UDP traffic, for use when it shares the MAC with another consumer;
- an address-management mode, which holds back all normal traffic until the station's IP address has been learnt from a reverse address-resolution reply.

The verdict is registered. It appears for one clock cycle, right after the last beat of a frame long enough to contain every inspected field.

Top module: `eth_rx_filter`

## Requirements
- R1: A frame of at least 42 beats gives exactly one cycle of `dec_valid`, in the clock cycle after the beat that carries `rx_last`. While `dec_valid` is low, `dec_class` is 0 and `dec_accept` is 0. Beats with `rx_valid` low are ignored, and byte 0 is the first valid beat.
- R2: A frame of fewer than 42 beats produces no `dec_valid`.
- R3: The effective enable is `en_pin` OR `en_cfg`. A frame that ends while both are low is dropped (class 0).
- R4: A frame whose last beat has `rx_error` high is dropped, whatever its contents.
- R5: Bytes 0..5 must equal `local_mac` (byte 0 is the most significant) or FF:FF:FF:FF:FF:FF. Otherwise the frame is dropped.
- R6: A UDP frame is delivered as class 1 when all of these hold:
  - the EtherType in bytes 12..13 is 0x0800;
  - byte 14 is 0x45;
  - byte 23 is 17;
  - bytes 30..33 equal `local_ip`;
  - bytes 36..37 equal `udp_port` (0xC351 is the customary value).
- R7: With `secondary` low, an address-resolution request is delivered as class 2 when all of these hold:
  - the EtherType is 0x0806;
  - bytes 14..17 are 00 01 08 00;
  - the opcode in bytes 20..21 is 1;
  - the target IP in bytes 38..41 equals `local_ip`.
  Any other opcode is dropped.
- R8: With `secondary` low, an echo request is delivered as class 3 when all of these hold:
  - the IPv4 conditions of R6 apart from the port;
  - byte 23 is 1;
  - byte 34 is 8.
  Any other ICMP type is dropped.
- R9: With `secondary` high, frames that would be class 2 or 3 are dropped, and UDP frames are still delivered as class 1.
- R10: While `ipam_mode` is high and `ip_known` is low, the only frame accepted is a reverse-resolution reply, delivered as class 4. Such a reply has EtherType 0x8035, bytes 14..17 equal to 00 01 08 00, opcode 4, and target hardware address (bytes 32..37) equal to `local_mac`. Every other frame, UDP included, is dropped.
- R11: Outside the pending state of R10, reverse-resolution frames are dropped.
- R12: A frame with any EtherType other than 0x0800, 0x0806 or 0x8035 is dropped.
- R13: `dec_accept` is high exactly when `dec_valid` is high and `dec_class` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC-side clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_last | input | 1 | Final byte of the frame |
| rx_error | input | 1 | MAC flags the frame as bad (sampled with `rx_last`) |
| local_mac | input | 48 | Station MAC address |
| local_ip | input | 32 | Station IPv4 address |
| udp_port | input | 16 | UDP destination port to accept |
| en_pin | input | 1 | Enable from a pin |
| en_cfg | input | 1 | Enable from a configuration bit |
| secondary | input | 1 | Accept only UDP frames to `udp_port` |
| ipam_mode | input | 1 | Address management by reverse resolution is active |
| ip_known | input | 1 | A valid reverse-resolution reply has already been seen |
| dec_valid | output | 1 | Verdict strobe, one cycle per long-enough frame |
| dec_class | output | 3 | 0 drop, 1 UDP, 2 address request, 3 echo, 4 reverse reply |
| dec_accept | output | 1 | Verdict is not a drop |

## Verification
The assertions assume that the control and address inputs hold steady during the beat that carries `rx_last`, since that is the beat in which the verdict is formed. They also assume that `rx_last` is only meaningful together with `rx_valid`. The bench changes configuration only between frames, while `rx_valid` is low. It raises `rx_last` and `rx_error` only on the final valid beat and never leaves a frame unfinished. Idle gaps inside a frame are inserted with `rx_last` low.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;

  // Verdict encoding.
  typedef enum logic [2:0] {
    CLS_DROP = 3'd0,
    CLS_UDP  = 3'd1,
    CLS_ARPQ = 3'd2,
    CLS_ECHO = 3'd3,
    CLS_RREP = 3'd4
  } frame_class_e;

  // Beats needed before every inspected field has been seen.
  localparam int HDR_LEN = 42;
  localparam int IDX_W   = $clog2(HDR_LEN + 1);
  localparam int REF_W   = 48;

  // Field comparator indices.
  localparam int F_DST_UC  = 0;
  localparam int F_DST_BC  = 1;
  localparam int F_ET_IP   = 2;
  localparam int F_ET_ARP  = 3;
  localparam int F_ET_RARP = 4;
  localparam int F_VIHL    = 5;
  localparam int F_PR_UDP  = 6;
  localparam int F_PR_ICMP = 7;
  localparam int F_DIP     = 8;
  localparam int F_ICMP_T  = 9;
  localparam int F_DPORT   = 10;
  localparam int F_HWPR    = 11;
  localparam int F_OP_REQ  = 12;
  localparam int F_OP_RREP = 13;
  localparam int F_TIP     = 14;
  localparam int F_THA     = 15;
  localparam int NF        = 16;

  // Byte offset and length for each comparator, following the wire format.
  localparam int FOFF [NF] = '{0, 0, 12, 12, 12, 14, 23, 23, 30, 34, 36, 14, 20, 20, 38, 32};
  localparam int FLEN [NF] = '{6, 6,  2,  2,  2,  1,  1,  1,  4,  1,  2,  4,  2,  2,  4,  6};

  // Fixed protocol constants.
  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] ET_ARP  = 16'h0806;
  localparam logic [15:0] ET_RARP = 16'h8035;
  localparam logic [7:0]  VER_IHL = 8'h45;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam logic [7:0]  PROTO_ICMP = 8'd1;
  localparam logic [7:0]  ICMP_ECHO_REQ = 8'd8;
  localparam logic [31:0] HW_PROTO_ETH_IP = 32'h0001_0800;
  localparam logic [15:0] OP_REQUEST = 16'd1;
  localparam logic [15:0] OP_RREPLY  = 16'd4;

endpackage

// File: rtl/ef_beat_counter.sv
// Index of the current beat within the frame, saturating past the header.
module ef_beat_counter #(
  parameter int MAX = 42,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         last,
  output logic [W-1:0] idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (valid) begin
      if (last) begin
        idx <= '0;
      end else if (idx != W'(MAX)) begin
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ef_field_match.sv
// Compares LEN bytes starting at beat OFF with a reference, most significant
// byte first. hit_now includes the byte on the current beat.
module ef_field_match #(
  parameter int OFF   = 0,
  parameter int LEN   = 1,
  parameter int IDX_W = 6,
  parameter int REF_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic [REF_W-1:0] ref_val,
  output logic             hit_now
);

  logic       flag;
  logic       in_rng;
  logic [7:0] ref_byte;
  logic       base;

  always_comb begin
    in_rng   = 1'b0;
    ref_byte = '0;
    for (int k = 0; k < LEN; k++) begin
      if (idx == IDX_W'(OFF + k)) begin
        in_rng   = 1'b1;
        ref_byte = ref_val[(LEN-1-k)*8 +: 8];
      end
    end
  end

  assign base    = (idx == '0) ? 1'b1 : flag;
  assign hit_now = base & ~(in_rng & (data != ref_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b1;
    end else if (valid) begin
      flag <= hit_now;
    end
  end

endmodule

// File: rtl/ef_classify.sv
// Applies the acceptance policy at the end of a frame and registers the verdict.
module ef_classify
  import eth_filt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_end,
  input  logic          long_enough,
  input  logic [NF-1:0] hit,
  input  logic          err,
  input  logic          enable,
  input  logic          secondary,
  input  logic          pending,
  output logic          dec_valid,
  output frame_class_e  dec_class,
  output logic          dec_accept
);

  logic addr_ok, ip_ok, is_udp, is_echo, is_arpq, is_rrep, gate;
  frame_class_e cls_c;

  always_comb begin
    addr_ok = hit[F_DST_UC] | hit[F_DST_BC];
    ip_ok   = hit[F_ET_IP] & hit[F_VIHL] & hit[F_DIP];
    is_udp  = ip_ok & hit[F_PR_UDP] & hit[F_DPORT];
    is_echo = ip_ok & hit[F_PR_ICMP] & hit[F_ICMP_T];
    is_arpq = hit[F_ET_ARP] & hit[F_HWPR] & hit[F_OP_REQ] & hit[F_TIP];
    is_rrep = hit[F_ET_RARP] & hit[F_HWPR] & hit[F_OP_RREP] & hit[F_THA];
    gate    = enable & ~err & addr_ok;

    cls_c = CLS_DROP;
    if (gate) begin
      if (pending) begin
        cls_c = is_rrep ? CLS_RREP : CLS_DROP;
      end else if (is_udp) begin
        cls_c = CLS_UDP;
      end else if (!secondary && is_arpq) begin
        cls_c = CLS_ARPQ;
      end else if (!secondary && is_echo) begin
        cls_c = CLS_ECHO;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_class  <= CLS_DROP;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= frame_end & long_enough;
      dec_class  <= (frame_end & long_enough) ? cls_c : CLS_DROP;
      dec_accept <= frame_end & long_enough & (cls_c != CLS_DROP);
    end
  end

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_last,
  input  logic        rx_error,
  input  logic [47:0] local_mac,
  input  logic [31:0] local_ip,
  input  logic [15:0] udp_port,
  input  logic        en_pin,
  input  logic        en_cfg,
  input  logic        secondary,
  input  logic        ipam_mode,
  input  logic        ip_known,
  output logic        dec_valid,
  output logic [2:0]  dec_class,
  output logic        dec_accept
);

  logic [IDX_W-1:0] idx;
  logic [REF_W-1:0] fref [NF];
  logic [NF-1:0]    hit;
  frame_class_e     cls_q;

  ef_beat_counter #(.MAX(HDR_LEN), .W(IDX_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .valid (rx_valid),
    .last  (rx_last),
    .idx   (idx)
  );

  always_comb begin
    fref[F_DST_UC]  = local_mac;
    fref[F_DST_BC]  = {REF_W{1'b1}};
    fref[F_ET_IP]   = REF_W'(ET_IPV4);
    fref[F_ET_ARP]  = REF_W'(ET_ARP);
    fref[F_ET_RARP] = REF_W'(ET_RARP);
    fref[F_VIHL]    = REF_W'(VER_IHL);
    fref[F_PR_UDP]  = REF_W'(PROTO_UDP);
    fref[F_PR_ICMP] = REF_W'(PROTO_ICMP);
    fref[F_DIP]     = REF_W'(local_ip);
    fref[F_ICMP_T]  = REF_W'(ICMP_ECHO_REQ);
    fref[F_DPORT]   = REF_W'(udp_port);
    fref[F_HWPR]    = REF_W'(HW_PROTO_ETH_IP);
    fref[F_OP_REQ]  = REF_W'(OP_REQUEST);
    fref[F_OP_RREP] = REF_W'(OP_RREPLY);
    fref[F_TIP]     = REF_W'(local_ip);
    fref[F_THA]     = local_mac;
  end

  for (genvar g = 0; g < NF; g++) begin : g_field
    ef_field_match #(
      .OFF   (FOFF[g]),
      .LEN   (FLEN[g]),
      .IDX_W (IDX_W),
      .REF_W (REF_W)
    ) u_fm (
      .clk     (clk),
      .rst     (rst),
      .valid   (rx_valid),
      .idx     (idx),
      .data    (rx_data),
      .ref_val (fref[g]),
      .hit_now (hit[g])
    );
  end

  ef_classify u_cls (
    .clk         (clk),
    .rst         (rst),
    .frame_end   (rx_valid & rx_last),
    .long_enough (idx >= IDX_W'(HDR_LEN - 1)),
    .hit         (hit),
    .err         (rx_error),
    .enable      (en_pin | en_cfg),
    .secondary   (secondary),
    .pending     (ipam_mode & ~ip_known),
    .dec_valid   (dec_valid),
    .dec_class   (cls_q),
    .dec_accept  (dec_accept)
  );

  assign dec_class = cls_q;

endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  rx_data,
  input logic        rx_valid,
  input logic        rx_last,
  input logic        rx_error,
  input logic [47:0] local_mac,
  input logic [31:0] local_ip,
  input logic [15:0] udp_port,
  input logic        en_pin,
  input logic        en_cfg,
  input logic        secondary,
  input logic        ipam_mode,
  input logic        ip_known,
  input logic        dec_valid,
  input logic [2:0]  dec_class,
  input logic        dec_accept
);

  // R1: a verdict only follows a final beat
  assert_strobe_after_last_R1: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(rx_valid && rx_last));

  // R1: idle outputs are zero
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (dec_class == 3'd0 && !dec_accept));

  // R3: no acceptance while both enables are low
  assert_disabled_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && !en_pin && !en_cfg) |=> !dec_accept);

  // R4: error at end of frame drops it
  assert_error_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && rx_error) |=> !dec_accept);

  // R9: internal classes are never produced in secondary mode
  assert_secondary_udp_only_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && secondary) |=> (dec_class != 3'd2 && dec_class != 3'd3));

  // R10: while the address is pending only the reverse reply class passes
  assert_pending_rrep_only_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && ipam_mode && !ip_known) |=> (dec_class == 3'd0 || dec_class == 3'd4));

  // R11: reverse replies are not delivered once the address is settled
  assert_no_rrep_settled_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && !(ipam_mode && !ip_known)) |=> dec_class != 3'd4);

  // R13: accept agrees with valid and class
  assert_accept_match_R13: assert property (@(posedge clk) disable iff (rst)
    dec_accept == (dec_valid && dec_class != 3'd0));

endmodule

bind eth_rx_filter eth_rx_filter_chk u_chk (.*);

// File: tb/sim_eth_rx_filter.sv
`timescale 1ns/1ps
module sim_eth_rx_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_error = 1'b0;
  logic [47:0] local_mac = 48'h02_11_22_33_44_55;
  logic [31:0] local_ip  = 32'hC0A8_0102;
  logic [15:0] udp_port  = 16'hC351;
  logic        en_pin = 1'b1, en_cfg = 1'b0, secondary = 1'b0;
  logic        ipam_mode = 1'b0, ip_known = 1'b0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_class;

  int n_chk = 0, n_fail = 0;
  logic [7:0] fb [64];
  int flen;

  always #2 clk = ~clk;

  eth_rx_filter u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int off, input int len, input logic [47:0] v);
    for (int k = 0; k < len; k++) fb[off+k] = v[(len-1-k)*8 +: 8];
  endtask

  task automatic mk_eth(input logic [47:0] dst, input logic [15:0] et, input int len);
    for (int k = 0; k < 64; k++) fb[k] = 8'h00;
    put(0, 6, dst);
    put(6, 6, 48'h0A_BB_CC_DD_EE_01);
    put(12, 2, 48'(et));
    flen = len;
  endtask

  task automatic mk_ip(input logic [47:0] dst, input logic [7:0] proto, input logic [31:0] ip);
    mk_eth(dst, 16'h0800, 42);
    fb[14] = 8'h45;
    fb[23] = proto;
    put(26, 4, 48'hC0A8_0001);
    put(30, 4, 48'(ip));
  endtask

  task automatic mk_udp(input logic [47:0] dst, input logic [31:0] ip, input logic [15:0] port);
    mk_ip(dst, 8'd17, ip);
    put(34, 2, 48'h1234);
    put(36, 2, 48'(port));
  endtask

  task automatic mk_echo(input logic [7:0] typ);
    mk_ip(local_mac, 8'd1, local_ip);
    fb[34] = typ;
  endtask

  task automatic mk_arp(input logic [15:0] et, input logic [15:0] op,
                        input logic [47:0] tha, input logic [31:0] tip);
    mk_eth(48'hFFFF_FFFF_FFFF, et, 42);
    put(14, 4, 48'h0001_0800);
    fb[18] = 8'd6; fb[19] = 8'd4;
    put(20, 2, 48'(op));
    put(32, 6, tha);
    put(38, 4, 48'(tip));
  endtask

  // Drives the frame in fb, then samples the verdict the cycle after the last beat.
  task automatic run(input string req, input bit err, input bit gaps,
                     input bit exp_v, input int exp_cls);
    for (int i = 0; i < flen; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fb[i];
      rx_last  = (i == flen - 1);
      rx_error = err && (i == flen - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_error = 1'b0;
    check(dec_valid == exp_v, req, "dec_valid", int'(dec_valid), int'(exp_v));
    if (exp_v) begin
      check(int'(dec_class) == exp_cls, req, "dec_class", int'(dec_class), exp_cls);
      check(dec_accept == (exp_cls != 0), "R13", "dec_accept", int'(dec_accept), int'(exp_cls != 0));
    end
    @(negedge clk);
    check(dec_valid == 1'b0, "R1", "strobe width", int'(dec_valid), 0);
  endtask

  task automatic t_reset;
    check(dec_valid == 1'b0 && dec_class == 3'd0 && dec_accept == 1'b0, "R1",
          "reset outputs", int'({dec_valid, dec_class, dec_accept}), 0);
  endtask

  task automatic t_udp;
    mk_udp(local_mac, local_ip, udp_port);            run("R6", 0, 0, 1, 1);
    mk_udp(local_mac, local_ip, udp_port); flen = 60; run("R1", 0, 1, 1, 1);
    mk_udp(local_mac, local_ip, 16'hC352);            run("R6", 0, 0, 1, 0);
    mk_udp(local_mac, 32'hC0A8_0103, udp_port);       run("R6", 0, 0, 1, 0);
    mk_udp(local_mac, local_ip, udp_port); fb[14] = 8'h46; run("R6", 0, 0, 1, 0);
  endtask

  task automatic t_mac;
    mk_udp(48'hFFFF_FFFF_FFFF, local_ip, udp_port);   run("R5", 0, 0, 1, 1);
    mk_udp(48'h02_11_22_33_44_56, local_ip, udp_port); run("R5", 0, 0, 1, 0);
  endtask

  task automatic t_arp;
    mk_arp(16'h0806, 16'd1, 48'h0, local_ip);           run("R7", 0, 0, 1, 2);
    mk_arp(16'h0806, 16'd2, 48'h0, local_ip);           run("R7", 0, 0, 1, 0);
    mk_arp(16'h0806, 16'd1, 48'h0, 32'hC0A8_0109);      run("R7", 0, 0, 1, 0);
  endtask

  task automatic t_echo;
    mk_echo(8'd8); run("R8", 0, 0, 1, 3);
    mk_echo(8'd0); run("R8", 0, 0, 1, 0);
  endtask

  task automatic t_secondary;
    secondary = 1'b1;
    mk_arp(16'h0806, 16'd1, 48'h0, local_ip); run("R9", 0, 0, 1, 0);
    mk_echo(8'd8);                            run("R9", 0, 0, 1, 0);
    mk_udp(local_mac, local_ip, udp_port);    run("R9", 0, 0, 1, 1);
    secondary = 1'b0;
  endtask

  task automatic t_enable;
    en_pin = 1'b0;
    mk_udp(local_mac, local_ip, udp_port); run("R3", 0, 0, 1, 0);
    en_cfg = 1'b1;
    mk_udp(local_mac, local_ip, udp_port); run("R3", 0, 0, 1, 1);
    en_pin = 1'b1; en_cfg = 1'b0;
  endtask

  task automatic t_error;
    mk_udp(local_mac, local_ip, udp_port); run("R4", 1, 0, 1, 0);
    mk_echo(8'd8);                         run("R4", 1, 1, 1, 0);
  endtask

  task automatic t_short;
    mk_udp(local_mac, local_ip, udp_port); flen = 41; run("R2", 0, 0, 0, 0);
    mk_udp(local_mac, local_ip, udp_port); flen = 14; run("R2", 0, 0, 0, 0);
    mk_udp(local_mac, local_ip, udp_port);            run("R2", 0, 0, 1, 1);
  endtask

  task automatic t_pending;
    ipam_mode = 1'b1; ip_known = 1'b0;
    mk_udp(local_mac, local_ip, udp_port);          run("R10", 0, 0, 1, 0);
    mk_arp(16'h0806, 16'd1, 48'h0, local_ip);       run("R10", 0, 0, 1, 0);
    mk_arp(16'h8035, 16'd4, local_mac, 32'h0);      run("R10", 0, 0, 1, 4);
    mk_arp(16'h8035, 16'd4, 48'h02_11_22_33_44_00, 32'h0); run("R10", 0, 0, 1, 0);
    mk_arp(16'h8035, 16'd3, local_mac, 32'h0);      run("R10", 0, 0, 1, 0);
    ip_known = 1'b1;
    mk_arp(16'h8035, 16'd4, local_mac, 32'h0);      run("R11", 0, 0, 1, 0);
    mk_udp(local_mac, local_ip, udp_port);          run("R10", 0, 0, 1, 1);
    ipam_mode = 1'b0;
    mk_arp(16'h8035, 16'd4, local_mac, 32'h0);      run("R11", 0, 0, 1, 0);
  endtask

  task automatic t_ethertype;
    mk_udp(local_mac, local_ip, udp_port); put(12, 2, 48'h86DD); run("R12", 0, 0, 1, 0);
    mk_arp(16'h0842, 16'd1, 48'h0, local_ip);                    run("R12", 0, 0, 1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_udp();
    t_mac();
    t_arp();
    t_echo();
    t_secondary();
    t_enable();
    t_error();
    t_short();
    t_pending();
    t_ethertype();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule